// File: doc/BRIEF.md
# Floating-Side Handshake Responder

This controller runs on the floating high-side driver of a half-bridge. It has no direct view of the gate command. Instead, two current detectors on its coupling-capacitor switch report pulses of either polarity, and the controller reads those pulses to decide what to do.

- A pulse of the "up" polarity requests a rising transition. The controller flips its capacitor switch, which sends a handshake pulse back across the capacitor. After a deadtime it turns the high-side gate on.
- A pulse of the "down" polarity requests a falling transition. The controller flips the capacitor switch back and turns the gate off in the same clock cycle.

All timing is counted in clock cycles and supplied on configuration pins: the start-up hold-off, the blanking window after each transition, the deadtime and the maximum on-time. If the gate stays on past the maximum on-time with no down pulse, the controller forces the gate off and latches a fault.

The block has no data stream. It has no valid/ready interface, and all of its pins are plain control or status lines.

Top module: `fdr_responder`

## Requirements
- R1: While reset is asserted, and after it is released, `cap_sel_o`, `gate_o` and `fault_o` are 0. Detector events that reach the sequencer within the first `t_init_i`+1 clock edges after reset release are ignored.
- R2: Each detector input passes through two synchronizing flops, and only a 0-to-1 change counts as an event. A level held high produces exactly one event, and an input high for a single clock cycle still produces one.
- R3: An accepted up event in the off state sets `cap_sel_o` to 1 on the third rising clock edge after the up input rises. The gate stays 0 at that point.
- R4: `gate_o` rises exactly `t_dead_i` clock edges after `cap_sel_o` rises (for `t_dead_i` of 1 or more), and only while `cap_sel_o` is 1.
- R5: An accepted down event while the gate is on clears `gate_o` and `cap_sel_o` on the same edge. That edge is the third rising edge after the down input rises.
- R6: A down event while the gate is off, and an up event while the gate is on, have no effect.
- R7: When `cap_sel_o` or `gate_o` changes, a blanking window opens. Detector events that reach the sequencer within `t_mask_i` edges after that change are discarded, not deferred.
- R8: If the gate stays on for `t_maxon_i` edges with no accepted down event, `gate_o` and `cap_sel_o` fall and `fault_o` rises on the same edge.
- R9: Once set, `fault_o` holds and every detector event is ignored until reset.
- R10: Up events that arrive during the deadtime do not restart or shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low power-on reset |
| sense_up_i | input | 1 | Asynchronous detector output, rising-transition polarity |
| sense_dn_i | input | 1 | Asynchronous detector output, falling-transition polarity |
| t_init_i | input | CNT_W | Start-up hold-off, in cycles |
| t_mask_i | input | CNT_W | Blanking window after each transition, in cycles |
| t_dead_i | input | CNT_W | Deadtime before the gate turns on, in cycles |
| t_maxon_i | input | CNT_W | Maximum gate on-time before a fault, in cycles |
| cap_sel_o | output | 1 | Capacitor switch select (1 = switched for the on state) |
| gate_o | output | 1 | High-side gate enable |
| fault_o | output | 1 | Latched on-time fault |

## Verification
The bench targets the following corner cases:

- The deadtime edge, checked one cycle early and exactly on time. An off-by-one counter shows up as a gate that rises a cycle early or late.
- An up pulse placed inside the deadtime. A design that re-arms on that pulse delays the gate.
- Events timed one edge inside the blanking window. A design that queues those events, or that opens the window one cycle short, switches when it should hold.
- A down level held high across the end of the blanking window. A level-sensitive design drops the gate as soon as blanking lifts.
- The on-time timeout and the fault that follows it. A design whose fault is not sticky answers later pulses instead of staying parked.

// File: rtl/fdr_pkg.sv
`timescale 1ns/1ps
package fdr_pkg;
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_OFF   = 3'd1,
    ST_DEAD  = 3'd2,
    ST_ON    = 3'd3,
    ST_FAULT = 3'd4
  } fdr_state_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned N_SENSE     = 2;
endpackage

// File: rtl/fdr_edge_sync.sv
`timescale 1ns/1ps
module fdr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic event_o
);
  // STAGES synchronizing flops plus one history flop for edge detection
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], raw_i};
  end

  assign event_o = shreg[STAGES-1] & ~shreg[STAGES];

  AST_SINGLE_CYCLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> !event_o); // R2
endmodule

// File: rtl/fdr_blank_timer.sv
`timescale 1ns/1ps
module fdr_blank_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         busy_o
);
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (load_i)          remain <= len_i;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign busy_o = (remain != '0);

  AST_BLANK_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> (remain == $past(remain) - 1'b1)); // R7
endmodule

// File: rtl/fdr_seq.sv
`timescale 1ns/1ps
module fdr_seq
  import fdr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_ev_i,
  input  logic         dn_ev_i,
  input  logic         blank_i,
  input  logic [W-1:0] t_init_i,
  input  logic [W-1:0] t_dead_i,
  input  logic [W-1:0] t_maxon_i,
  output logic         mark_o,
  output logic         cap_sel_o,
  output logic         gate_o,
  output logic         fault_o
);
  fdr_state_e   st;
  logic [W-1:0] cnt;
  logic [W:0]   cnt_inc;
  logic         up_ok, dn_ok, dead_done, on_expired, init_done;

  assign cnt_inc    = {1'b0, cnt} + 1'b1;
  assign up_ok      = up_ev_i & ~blank_i;
  assign dn_ok      = dn_ev_i & ~blank_i;
  assign init_done  = (cnt >= t_init_i);
  assign dead_done  = (cnt_inc >= {1'b0, t_dead_i});
  assign on_expired = (cnt_inc >= {1'b0, t_maxon_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_INIT;
      cnt <= '0;
    end else begin
      case (st)
        ST_INIT: begin
          if (init_done) begin st <= ST_OFF; cnt <= '0; end
          else cnt <= cnt_inc[W-1:0];
        end
        ST_OFF: begin
          if (up_ok) begin st <= ST_DEAD; cnt <= '0; end
        end
        ST_DEAD: begin
          if (dead_done) begin st <= ST_ON; cnt <= '0; end
          else cnt <= cnt_inc[W-1:0];
        end
        ST_ON: begin
          if (dn_ok)           begin st <= ST_OFF;   cnt <= '0; end
          else if (on_expired) begin st <= ST_FAULT; cnt <= '0; end
          else cnt <= cnt_inc[W-1:0];
        end
        ST_FAULT: st <= ST_FAULT;
        default:  st <= ST_FAULT;
      endcase
    end
  end

  // a blanking window opens whenever the capacitor switch or the gate changes
  always_comb begin
    mark_o = 1'b0;
    case (st)
      ST_OFF:  mark_o = up_ok;
      ST_DEAD: mark_o = dead_done;
      ST_ON:   mark_o = dn_ok | on_expired;
      default: mark_o = 1'b0;
    endcase
  end

  assign cap_sel_o = (st == ST_DEAD) || (st == ST_ON);
  assign gate_o    = (st == ST_ON);
  assign fault_o   = (st == ST_FAULT);

  AST_GATE_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(cap_sel_o)); // R4
  AST_CAP_DROP_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_sel_o) |-> !gate_o); // R5
  AST_WRONG_POLARITY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && dn_ev_i && !up_ev_i) |=> (st == ST_OFF)); // R6
  AST_BLANK_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && blank_i) |=> (st != ST_DEAD)); // R7
  AST_FAULT_FROM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> ($past(gate_o) && !gate_o)); // R8
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o); // R9
  AST_DEAD_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEAD && !dead_done) |=> (st == ST_DEAD && cnt == $past(cnt) + 1'b1)); // R10
endmodule

// File: rtl/fdr_responder.sv
`timescale 1ns/1ps
module fdr_responder
  import fdr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sense_up_i,
  input  logic             sense_dn_i,
  input  logic [CNT_W-1:0] t_init_i,
  input  logic [CNT_W-1:0] t_mask_i,
  input  logic [CNT_W-1:0] t_dead_i,
  input  logic [CNT_W-1:0] t_maxon_i,
  output logic             cap_sel_o,
  output logic             gate_o,
  output logic             fault_o
);
  logic [N_SENSE-1:0] raw, ev;
  logic               blank, mark;

  assign raw = {sense_dn_i, sense_up_i};

  for (genvar g = 0; g < N_SENSE; g++) begin : g_sense
    fdr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw[g]),
      .event_o (ev[g])
    );
  end

  fdr_blank_timer #(.W(CNT_W)) u_blank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (mark),
    .len_i  (t_mask_i),
    .busy_o (blank)
  );

  fdr_seq #(.W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_ev_i   (ev[0]),
    .dn_ev_i   (ev[1]),
    .blank_i   (blank),
    .t_init_i  (t_init_i),
    .t_dead_i  (t_dead_i),
    .t_maxon_i (t_maxon_i),
    .mark_o    (mark),
    .cap_sel_o (cap_sel_o),
    .gate_o    (gate_o),
    .fault_o   (fault_o)
  );

  AST_RESET_OUTPUTS_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!cap_sel_o && !gate_o && !fault_o)); // R1
endmodule

// File: tb/fdr_responder_test.sv
`timescale 1ns/1ps
module fdr_responder_test;
  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sense_up, sense_dn;
  logic [W-1:0] t_init, t_mask, t_dead, t_maxon;
  logic         cap_sel, gate, fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fdr_responder #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .sense_up_i(sense_up), .sense_dn_i(sense_dn),
    .t_init_i(t_init), .t_mask_i(t_mask), .t_dead_i(t_dead), .t_maxon_i(t_maxon),
    .cap_sel_o(cap_sel), .gate_o(gate), .fault_o(fault)
  );

  // vector: [15] up, [14] dn, [13:6] cycles before check, [2] cap, [1] gate, [0] fault
  localparam int VEC_N = 11;
  localparam logic [15:0] VEC [VEC_N] = '{
    {1'b0, 1'b1, 8'd20, 3'b000, 3'b000},  // R6 down while off
    {1'b1, 1'b0, 8'd3,  3'b000, 3'b100},  // R3 up accepted
    {1'b0, 1'b0, 8'd2,  3'b000, 3'b100},  // idle inside deadtime
    {1'b1, 1'b0, 8'd10, 3'b000, 3'b110},  // R10 up during deadtime
    {1'b1, 1'b0, 8'd10, 3'b000, 3'b110},  // R6 up while on
    {1'b0, 1'b1, 8'd3,  3'b000, 3'b000},  // R5 down turns off
    {1'b1, 1'b0, 8'd10, 3'b000, 3'b000},  // R7 up inside blanking
    {1'b1, 1'b0, 8'd3,  3'b000, 3'b100},  // R3 up after blanking
    {1'b0, 1'b0, 8'd40, 3'b000, 3'b110},  // R4 gate on
    {1'b0, 1'b0, 8'd40, 3'b000, 3'b001},  // R8 on-time fault
    {1'b1, 1'b1, 8'd10, 3'b000, 3'b001}   // R9 fault ignores events
  };
  string vec_req [VEC_N];

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] got;
    got = {cap_sel, gate, fault};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {cap,gate,fault} actual %b expected %b", req, got, exp);
    end
  endtask

  // raise the chosen inputs for one cycle, then wait w negedges in total
  task automatic fire(input logic up, input logic dn, input int w);
    sense_up = up;
    sense_dn = dn;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (i == 0) begin sense_up = 1'b0; sense_dn = 1'b0; end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    vec_req = '{"R6", "R3", "R10", "R10", "R6", "R5", "R7", "R3", "R4", "R8", "R9"};
    rst_n = 1'b0; sense_up = 1'b0; sense_dn = 1'b0;
    t_init = 16'd20; t_mask = 16'd3; t_dead = 16'd8; t_maxon = 16'd60;
    repeat (3) @(negedge clk);
    check("R1 reset state", 3'b000);
    rst_n = 1'b1;
    fire(1'b1, 1'b0, 10);
    check("R1 up during start-up ignored", 3'b000);
    fire(1'b0, 1'b0, 20);
    // exact deadtime
    fire(1'b1, 1'b0, 3);
    check("R3 cap switched, gate off", 3'b100);
    fire(1'b0, 1'b0, 7);
    check("R4 gate still off one edge before deadtime", 3'b100);
    fire(1'b0, 1'b0, 1);
    check("R4 gate on at deadtime", 3'b110);
    fire(1'b0, 1'b1, 3);
    check("R7 down inside blanking discarded", 3'b110);
    fire(1'b0, 1'b1, 3);
    check("R5 down after blanking", 3'b000);

    for (int v = 0; v < VEC_N; v++) begin
      fire(VEC[v][15], VEC[v][14], int'(VEC[v][13:6]));
      check($sformatf("%s vector %0d", vec_req[v], v), VEC[v][2:0]);
    end

    // reset clears the fault
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears fault", 3'b000);
    rst_n = 1'b1;
    fire(1'b0, 1'b0, 30);
    fire(1'b1, 1'b0, 3);
    fire(1'b0, 1'b0, 8);
    check("R4 gate on after reset", 3'b110);
    // down level rises inside blanking and stays high past it
    sense_dn = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 held level is one event", 3'b110);
    sense_dn = 1'b0;
    fire(1'b0, 1'b0, 5);
    fire(1'b0, 1'b1, 3);
    check("R5 fresh down edge turns off", 3'b000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule